// File: doc/BRIEF.md
# Row/Column Request Packet Deserializer

This block gathers control packets that arrive serially on two narrow groups of request lanes and presents each one as a single wide word. The row group has three lanes. Eight consecutive bit-times on it form a 24-bit row word, tagged either as an activate request or as a row-operation request (precharge and the like). The column group has five lanes. Eight bit-times on it form a 40-bit column word. That word is split into a 23-bit operation field and a 17-bit companion field, and the companion field is tagged either as a byte-mask packet or as an extended-operation packet.

The two groups are framed independently. Each one waits idle until its most significant lane goes high. That bit-time becomes the first of the packet, and a 3-bit bit-time counter then collects the remaining seven. A finished packet appears with a one-cycle valid strobe in the cycle after its last sample. A new packet may begin in that same cycle, so packets can follow each other with no gap. Everything is sampled on a single receive clock. Decoding of commands beyond the type tags is left to downstream logic.

Top module: `rqpkt_deser`

## Requirements
- R1: After a synchronous active-high reset, `row_valid` and `col_valid` are low, and all data and tag outputs are zero.
- R2: A row packet is the eight samples of `row_lanes` taken from the start bit-time onward. The sample at bit-time t (0 to 7) fills `row_data[23-3t : 21-3t]`, with lane 2 at the highest position, so `row_data[23]` is always 1.
- R3: While a group is idle, a sample whose most significant lane is low is ignored and produces no valid strobe. This applies to `row_lanes[2]` for the row group and `col_lanes[4]` for the column group, whatever the other lanes carry.
- R4: Each completed packet raises its valid output for exactly one cycle. That cycle is the one that follows the clock edge taking the eighth sample.
- R5: `row_kind` is 1 (activate) when `row_data[22]` is 1, and 0 (row operation) otherwise.
- R6: A column packet is assembled the same way, with sample t filling bits [39-5t : 35-5t] of a 40-bit word and lane 4 highest. `col_op` carries word bits [39:17], so `col_op[22]` is 1, and `col_sub` carries word bits [16:0].
- R7: `col_sub_kind` is 1 (mask packet) when `col_sub[16]` is 1, and 0 (extended-operation packet) otherwise.
- R8: A start bit-time presented in the cycle where the previous packet's valid is high is accepted. Back-to-back packets therefore produce valid strobes exactly 8 cycles apart, and never closer.
- R9: The row and column groups run independently. Packets started in the same cycle on both groups complete in the same cycle, and each group's result is unaffected by the other.
- R10: Once a packet has started, a high most significant lane at bit-times 1 to 7 is packet data and does not restart framing.
- R11: Data and tag outputs hold their last packet's value in every cycle where the group's valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock; lanes sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| row_lanes | input | 3 | Row request lanes, bit 2 carries the start flag |
| col_lanes | input | 5 | Column request lanes, bit 4 carries the start flag |
| row_valid | output | 1 | One-cycle strobe for a completed row packet |
| row_kind | output | 1 | 1 = activate, 0 = row operation |
| row_data | output | 24 | Assembled row packet |
| col_valid | output | 1 | One-cycle strobe for a completed column packet |
| col_op | output | 23 | Column-operation field |
| col_sub | output | 17 | Second column field (mask or extended) |
| col_sub_kind | output | 1 | 1 = mask packet, 0 = extended-operation packet |

## Verification
Two things can land in the same cycle: a row completion and a column completion, and one packet's valid strobe with the next packet's start bit-time on the same lanes. The bench starts a row packet and a column packet on the same edge, and it sends runs of packets with no idle bit-time between them. A scoreboard stores each expected word with the cycle in which its strobe must appear, and it judges every strobe against that cycle, the word and the tag. Any strobe that arrives when no packet is pending, including one caused by idle noise on the lower lanes, counts as a failure.

// File: rtl/rqd_pkg.sv
package rqd_pkg;

    localparam int ROW_LANES    = 3;
    localparam int COL_LANES    = 5;
    localparam int BIT_TIMES    = 8;
    localparam int ROW_W        = ROW_LANES * BIT_TIMES;
    localparam int COL_W        = COL_LANES * BIT_TIMES;
    localparam int SUB_W        = 17;
    localparam int OP_W         = COL_W - SUB_W;
    localparam int ROW_KIND_BIT = ROW_W - 2;
    localparam int SUB_KIND_BIT = SUB_W - 1;

    typedef enum logic {
        ROW_OPER = 1'b0,
        ROW_ACT  = 1'b1
    } row_kind_e;

    typedef enum logic {
        SUB_EXT  = 1'b0,
        SUB_MASK = 1'b1
    } sub_kind_e;

    typedef struct packed {
        row_kind_e         kind;
        logic [ROW_W-1:0]  bits;
    } row_pkt_t;

    typedef struct packed {
        sub_kind_e         kind;
        logic [OP_W-1:0]   op;
        logic [SUB_W-1:0]  sub;
    } col_pkt_t;

    function automatic row_kind_e row_kind_of(input logic [ROW_W-1:0] w);
        return w[ROW_KIND_BIT] ? ROW_ACT : ROW_OPER;
    endfunction

    function automatic sub_kind_e sub_kind_of(input logic [SUB_W-1:0] s);
        return s[SUB_KIND_BIT] ? SUB_MASK : SUB_EXT;
    endfunction

endpackage

// File: rtl/rqd_lane_deser.sv
module rqd_lane_deser #(
    parameter int LANES = 3,
    parameter int BEATS = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [LANES-1:0]         lanes,
    output logic                     done,
    output logic [LANES*BEATS-1:0]   word
);
    localparam int W  = LANES * BEATS;
    localparam int SW = W - LANES;
    localparam int CW = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam logic [CW-1:0] LAST = CW'(BEATS - 1);

    logic          busy;
    logic [CW-1:0] beat;
    logic [SW-1:0] shreg;
    logic [SW-1:0] shreg_next;

    generate
        if (SW > LANES) begin : g_shift
            assign shreg_next = {shreg[SW-LANES-1:0], lanes};
        end else begin : g_load
            assign shreg_next = SW'(lanes);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            beat  <= '0;
            shreg <= '0;
            done  <= 1'b0;
            word  <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (lanes[LANES-1]) begin
                    busy  <= 1'b1;
                    beat  <= CW'(1);
                    shreg <= shreg_next;
                end
            end else if (beat == LAST) begin
                word  <= {shreg, lanes};
                done  <= 1'b1;
                busy  <= 1'b0;
                beat  <= '0;
            end else begin
                shreg <= shreg_next;
                beat  <= beat + CW'(1);
            end
        end
    end
endmodule

// File: rtl/rqd_row_classify.sv
module rqd_row_classify
    import rqd_pkg::*;
(
    input  logic [ROW_W-1:0] word,
    output row_pkt_t         pkt
);
    always_comb begin
        pkt.bits = word;
        pkt.kind = row_kind_of(word);
    end
endmodule

// File: rtl/rqd_col_split.sv
module rqd_col_split
    import rqd_pkg::*;
(
    input  logic [COL_W-1:0] word,
    output col_pkt_t         pkt
);
    always_comb begin
        pkt.op   = word[COL_W-1:SUB_W];
        pkt.sub  = word[SUB_W-1:0];
        pkt.kind = sub_kind_of(word[SUB_W-1:0]);
    end
endmodule

// File: rtl/rqpkt_deser.sv
module rqpkt_deser
    import rqd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ROW_LANES-1:0]  row_lanes,
    input  logic [COL_LANES-1:0]  col_lanes,
    output logic                  row_valid,
    output logic                  row_kind,
    output logic [ROW_W-1:0]      row_data,
    output logic                  col_valid,
    output logic [OP_W-1:0]       col_op,
    output logic [SUB_W-1:0]      col_sub,
    output logic                  col_sub_kind
);
    logic [ROW_W-1:0] row_word;
    logic [COL_W-1:0] col_word;
    row_pkt_t         row_pkt;
    col_pkt_t         col_pkt;

    rqd_lane_deser #(.LANES(ROW_LANES), .BEATS(BIT_TIMES)) u_row_deser (
        .clk   (clk),
        .rst   (rst),
        .lanes (row_lanes),
        .done  (row_valid),
        .word  (row_word)
    );

    rqd_lane_deser #(.LANES(COL_LANES), .BEATS(BIT_TIMES)) u_col_deser (
        .clk   (clk),
        .rst   (rst),
        .lanes (col_lanes),
        .done  (col_valid),
        .word  (col_word)
    );

    rqd_row_classify u_row_cls (
        .word (row_word),
        .pkt  (row_pkt)
    );

    rqd_col_split u_col_split (
        .word (col_word),
        .pkt  (col_pkt)
    );

    assign row_data     = row_pkt.bits;
    assign row_kind     = row_pkt.kind;
    assign col_op       = col_pkt.op;
    assign col_sub      = col_pkt.sub;
    assign col_sub_kind = col_pkt.kind;
endmodule

// File: rtl/rqd_checker.sv
module rqd_checker
    import rqd_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 row_valid,
    input logic                 row_kind,
    input logic [ROW_W-1:0]     row_data,
    input logic                 col_valid,
    input logic [OP_W-1:0]      col_op,
    input logic [SUB_W-1:0]     col_sub,
    input logic                 col_sub_kind
);
    localparam int GW = $clog2(BIT_TIMES) + 1;
    localparam logic [GW-1:0] GMAX = '1;

    logic [GW-1:0] row_gap, col_gap;
    logic          row_seen, col_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            row_gap  <= '0;
            col_gap  <= '0;
            row_seen <= 1'b0;
            col_seen <= 1'b0;
        end else begin
            if (row_valid) begin
                row_gap  <= '0;
                row_seen <= 1'b1;
            end else if (row_gap != GMAX) begin
                row_gap <= row_gap + GW'(1);
            end
            if (col_valid) begin
                col_gap  <= '0;
                col_seen <= 1'b1;
            end else if (col_gap != GMAX) begin
                col_gap <= col_gap + GW'(1);
            end
        end
    end

    assert_row_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        row_valid |=> !row_valid);
    assert_col_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        col_valid |=> !col_valid);
    assert_row_gap_R8: assert property (@(posedge clk) disable iff (rst)
        (row_valid && row_seen) |-> (row_gap >= GW'(BIT_TIMES - 1)));
    assert_col_gap_R8: assert property (@(posedge clk) disable iff (rst)
        (col_valid && col_seen) |-> (col_gap >= GW'(BIT_TIMES - 1)));
    assert_row_start_R2: assert property (@(posedge clk) disable iff (rst)
        row_valid |-> row_data[ROW_W-1]);
    assert_col_start_R6: assert property (@(posedge clk) disable iff (rst)
        col_valid |-> col_op[OP_W-1]);
    assert_row_kind_R5: assert property (@(posedge clk) disable iff (rst)
        row_valid |-> (row_kind == row_data[ROW_KIND_BIT]));
    assert_sub_kind_R7: assert property (@(posedge clk) disable iff (rst)
        col_valid |-> (col_sub_kind == col_sub[SUB_KIND_BIT]));
    assert_row_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !row_valid |-> ($stable(row_data) && $stable(row_kind)));
    assert_col_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !col_valid |-> ($stable(col_op) && $stable(col_sub) && $stable(col_sub_kind)));
endmodule

bind rqpkt_deser rqd_checker u_rqd_chk (
    .clk          (clk),
    .rst          (rst),
    .row_valid    (row_valid),
    .row_kind     (row_kind),
    .row_data     (row_data),
    .col_valid    (col_valid),
    .col_op       (col_op),
    .col_sub      (col_sub),
    .col_sub_kind (col_sub_kind)
);

// File: tb/rqpkt_deser_tb_top.sv
module rqpkt_deser_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  row_lanes = '0;
    logic [4:0]  col_lanes = '0;
    logic        row_valid, row_kind, col_valid, col_sub_kind;
    logic [23:0] row_data;
    logic [22:0] col_op;
    logic [16:0] col_sub;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done_flag = 0;

    logic [23:0] row_q[$];
    int          row_t[$];
    logic [39:0] col_q[$];
    int          col_t[$];
    logic [23:0] last_row = '0;
    logic [39:0] last_col = '0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rqpkt_deser dut_i (
        .clk(clk), .rst(rst), .row_lanes(row_lanes), .col_lanes(col_lanes),
        .row_valid(row_valid), .row_kind(row_kind), .row_data(row_data),
        .col_valid(col_valid), .col_op(col_op), .col_sub(col_sub),
        .col_sub_kind(col_sub_kind)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Driver tasks: called at a falling edge, leave at a falling edge.
    task automatic send_row(input logic [23:0] p);
        for (int t = 0; t < 8; t++) begin
            row_lanes = p[23-3*t -: 3];
            if (t == 0) begin
                row_q.push_back(p);
                row_t.push_back(cyc + 8);
            end
            @(negedge clk);
        end
        row_lanes = '0;
    endtask

    task automatic send_col(input logic [39:0] p);
        for (int t = 0; t < 8; t++) begin
            col_lanes = p[39-5*t -: 5];
            if (t == 0) begin
                col_q.push_back(p);
                col_t.push_back(cyc + 8);
            end
            @(negedge clk);
        end
        col_lanes = '0;
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && !done_flag) begin
            if (row_valid) begin
                if (row_q.size() == 0) begin
                    chk(0, "R3 unexpected row_valid", 64'(row_data), 0);
                end else begin
                    logic [23:0] e;
                    int et;
                    e = row_q.pop_front();
                    et = row_t.pop_front();
                    chk(row_data == e, "R2 row_data", 64'(row_data), 64'(e));
                    chk(row_kind == e[22], "R5 row_kind", 64'(row_kind), 64'(e[22]));
                    chk(cyc == et, "R4/R8 row valid cycle", 64'(cyc), 64'(et));
                    last_row = e;
                end
            end else begin
                chk(row_data == last_row && row_kind == last_row[22], "R11 row hold",
                    64'(row_data), 64'(last_row));
            end
            if (col_valid) begin
                if (col_q.size() == 0) begin
                    chk(0, "R3 unexpected col_valid", 64'(col_op), 0);
                end else begin
                    logic [39:0] e;
                    int et;
                    e = col_q.pop_front();
                    et = col_t.pop_front();
                    chk(col_op == e[39:17], "R6 col_op", 64'(col_op), 64'(e[39:17]));
                    chk(col_sub == e[16:0], "R6 col_sub", 64'(col_sub), 64'(e[16:0]));
                    chk(col_sub_kind == e[16], "R7 col_sub_kind", 64'(col_sub_kind), 64'(e[16]));
                    chk(cyc == et, "R4/R8/R9 col valid cycle", 64'(cyc), 64'(et));
                    last_col = e;
                end
            end else begin
                chk({col_op, col_sub} == last_col && col_sub_kind == last_col[16],
                    "R11 col hold", 64'({col_op, col_sub}), 64'(last_col));
            end
        end
    end

    function automatic logic [23:0] mk_row(input bit act);
        logic [23:0] p;
        p = 24'($urandom);
        p[23] = 1'b1;
        p[22] = act;
        return p;
    endfunction

    function automatic logic [39:0] mk_col(input bit mask);
        logic [39:0] p;
        p = {8'($urandom), 32'($urandom)};
        p[39] = 1'b1;
        p[16] = mask;
        return p;
    endfunction

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=<20000", cyc);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(row_valid == 0 && col_valid == 0, "R1 valids in reset", 64'({row_valid, col_valid}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(row_data == 0 && row_kind == 0, "R1 row outputs after reset", 64'(row_data), 0);
        chk(col_op == 0 && col_sub == 0 && col_sub_kind == 0, "R1 col outputs after reset",
            64'({col_op, col_sub}), 0);

        // R2/R5: single row packets of each kind
        send_row(mk_row(1));
        repeat (3) @(negedge clk);
        send_row(mk_row(0));
        repeat (3) @(negedge clk);

        // R3: idle noise on lower lanes must be ignored
        row_lanes = 3'b011;
        col_lanes = 5'b01111;
        repeat (6) @(negedge clk);
        row_lanes = 3'b001;
        col_lanes = 5'b01010;
        repeat (6) @(negedge clk);
        row_lanes = '0;
        col_lanes = '0;
        repeat (12) @(negedge clk);

        // R6/R7: column packets, mask and extended
        send_col(mk_col(1));
        repeat (2) @(negedge clk);
        send_col(mk_col(0));
        repeat (3) @(negedge clk);

        // R10: start lane high through the whole packet
        send_row(24'hFFFFFF);
        send_col(40'hFF_FFFF_FFFF);
        repeat (2) @(negedge clk);

        // R8: back-to-back runs
        for (int i = 0; i < 4; i++) send_row(mk_row(i[0]));
        for (int i = 0; i < 4; i++) send_col(mk_col(i[1]));
        repeat (3) @(negedge clk);

        // R9: both groups started in the same cycle, some back to back
        for (int k = 0; k < 6; k++) begin
            fork
                send_row(mk_row(k[0]));
                send_col(mk_col(k[1]));
            join
            if (k == 2) repeat (2) @(negedge clk);
        end

        // Column started one cycle after a row packet
        fork
            send_row(mk_row(1));
            begin @(negedge clk); send_col(mk_col(1)); end
        join

        repeat (12) @(negedge clk);
        chk(row_q.size() == 0, "R4 row strobes missing", 64'(row_q.size()), 0);
        chk(col_q.size() == 0, "R4 col strobes missing", 64'(col_q.size()), 0);
        finish_run();
    end
endmodule